// File: doc/BRIEF.md
# Dual-Channel PWM Compare Output Generator

This block is an up/down timer with two compare channels, A and B. Each channel drives one waveform pin. The counter runs in one of four waveform modes:

- a free-running count that wraps at the all-ones value;
- a count that clears after matching the channel A compare value;
- a single-slope fast PWM count;
- a dual-slope phase-correct PWM count.

Each channel has a 2-bit output code. The code chooses whether a compare match toggles, clears or sets the pin, or whether the pin is left alone. In the PWM modes it also chooses what happens at the wrap point or at the turning points of the count.

Each pin has an output-enable. The enable is high only when the channel's code connects the pin and the channel's external direction bit is set. When the enable is low, a port can use the pin for ordinary I/O.

In the PWM modes the compare values pass through a shadow stage. The shadow stage is refreshed only at the counter's turning points, so a compare value written in the middle of a period cannot produce a short pulse. Prescaling and interrupts belong to the surrounding logic.

Top module: `pwm_cmp_gen`

## Requirements
- R1: Reset state. After reset both pins are low, the counter holds 0 and counts upward first, and both compare shadows hold 0.
- R2: Code 00 disconnects the pin. With code 2'b00 the output-enable is low and the pin value does not change, in every mode.
- R3: Pin driver gating. The output-enable of a pin is high exactly when its code connects the pin and its direction input is 1.
- R4: Counter sequence outside PWM. The mode code is `wave_mode`. In mode 2'b00 the counter wraps from 2^W-1 to 0. In mode 2'b01 the counter goes to 0 on the enabled cycle after it equals `cmp_a`.
- R5: Phase-correct count (mode 2'b11). The counter rises from 0 to `top_val`, then falls back to 0. It turns down at `top_val` and turns up at 0, and each end value is held for exactly one step.
- R6: Actions outside PWM (modes 2'b00 and 2'b01). When the counter equals the live compare value, the pin responds to the code: 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R7: Fast PWM (mode 2'b10). The counter runs 0..`top_val` and then wraps to 0. With code 1x, a match drives the pin to code bit 0. On the step that wraps from `top_val`, the pin is driven to the inverse of code bit 0.
- R8: In fast PWM, code 01 on channel B is reserved. It leaves the pin disconnected and unchanged.
- R9: Phase-correct actions with code 1x. A match while the count rises drives the pin to code bit 0. A match while it falls drives the pin to the inverse of code bit 0. The value 0 counts as rising and `top_val` counts as falling.
- R10: Code 01 on channel A in either PWM mode. When `mode_x` is 1, the pin toggles on a match. When `mode_x` is 0, the pin is disconnected and unchanged.
- R11: Compare value at the top. In the PWM modes, when a code 1x channel's compare value equals `top_val`, the match action is dropped. The pin is instead driven to the inverse of code bit 0 when the counter is at `top_val`.
- R12: Double buffering. In the PWM modes a compare input takes effect only after an enabled step that leaves `top_val`, or in phase-correct mode also one that leaves 0. Outside PWM the compare inputs act at once.
- R13: When `cnt_en` is 0, the counter, the direction and both pins hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable for this cycle |
| wave_mode | input | 2 | 00 wrap, 01 clear on A match, 10 fast PWM, 11 phase-correct PWM |
| mode_x | input | 1 | Extra mode bit that enables the channel A toggle in PWM modes |
| top_val | input | W | Top of the count in PWM modes |
| cmp_a | input | W | Channel A compare value |
| cmp_b | input | W | Channel B compare value |
| com_a | input | 2 | Channel A output code |
| com_b | input | 2 | Channel B output code |
| dir_a | input | 1 | Direction bit of pin A |
| dir_b | input | 1 | Direction bit of pin B |
| out_a | output | 1 | Waveform pin A |
| out_b | output | 1 | Waveform pin B |
| oe_a | output | 1 | Output-enable of pin A |
| oe_b | output | 1 | Output-enable of pin B |

## Verification
Every mode is driven with each output code on both channels, and the results are compared cycle by cycle with a reference model kept in the bench.

Compare values of 0 and of the top value are forced often. These cases separate the wrap and turning-point actions from the ordinary match actions, and they expose the special handling of a compare value at the top.

Compare values are also changed in the middle of a period. This separates a shadowed compare value from a live one.

Random gaps in the count enable check that no state moves without a step. Runs with the direction bits cleared, and with the reserved and mode_x-dependent codes, check that the output-enable follows the connect rule and not merely whether the code is nonzero.

// File: rtl/pwm_cmp_gen.sv
module pwm_cmp_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [1:0]   wave_mode,
  input  logic         mode_x,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   com_a,
  input  logic [1:0]   com_b,
  input  logic         dir_a,
  input  logic         dir_b,
  output logic         out_a,
  output logic         out_b,
  output logic         oe_a,
  output logic         oe_b
);
  localparam logic [W-1:0] ALL1  = '1;
  localparam logic [1:0] M_WRAP  = 2'b00;
  localparam logic [1:0] M_CLR   = 2'b01;
  localparam logic [1:0] M_FAST  = 2'b10;
  localparam logic [1:0] M_PHASE = 2'b11;

  logic [W-1:0] cnt_q, cnt_d, sh_a_q, sh_b_q, top;
  logic up_q, up_d, pin_a_q, pin_b_q;

  wire pwm    = wave_mode[1];
  wire phase  = (wave_mode == M_PHASE);
  wire at_top = (cnt_q == top);
  wire at_bot = (cnt_q == '0);
  wire rising = at_bot | (up_q & ~at_top);
  wire [W-1:0] ca = pwm ? sh_a_q : cmp_a;
  wire [W-1:0] cb = pwm ? sh_b_q : cmp_b;
  wire refresh = ~pwm | (cnt_en & (at_top | (phase & at_bot)));

  always_comb begin
    case (wave_mode)
      M_WRAP:  top = ALL1;
      M_CLR:   top = cmp_a;
      default: top = top_val;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!phase) begin
      up_d  = 1'b1;
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
    end else if (rising && !at_top) begin
      up_d  = 1'b1;
      cnt_d = cnt_q + 1'b1;
    end else begin
      up_d  = 1'b0;
      cnt_d = at_bot ? cnt_q : cnt_q - 1'b1;
    end
  end

  function automatic logic linked(input logic [1:0] code, input logic is_a,
                                  input logic pw, input logic mx);
    return (code != 2'b00) && !(pw && code == 2'b01 && !(is_a && mx));
  endfunction

  function automatic logic next_pin(input logic [1:0] code, input logic hit,
                                    input logic cur, input logic ok,
                                    input logic pw, input logic ph,
                                    input logic ttop, input logic rise);
    if (!ok)            return cur;
    if (code == 2'b01)  return hit ? ~cur : cur;
    if (!pw)            return hit ? code[0] : cur;
    if (!ph) begin
      if (ttop)         return ~code[0];
      return hit ? code[0] : cur;
    end
    return hit ? (rise ? code[0] : ~code[0]) : cur;
  endfunction

  wire link_a = linked(com_a, 1'b1, pwm, mode_x);
  wire link_b = linked(com_b, 1'b0, pwm, mode_x);
  wire nx_a = next_pin(com_a, cnt_q == ca, pin_a_q, link_a, pwm, phase, at_top, rising);
  wire nx_b = next_pin(com_b, cnt_q == cb, pin_b_q, link_b, pwm, phase, at_top, rising);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      up_q    <= 1'b1;
      pin_a_q <= 1'b0;
      pin_b_q <= 1'b0;
      sh_a_q  <= '0;
      sh_b_q  <= '0;
    end else begin
      if (cnt_en) begin
        cnt_q   <= cnt_d;
        up_q    <= up_d;
        pin_a_q <= nx_a;
        pin_b_q <= nx_b;
      end
      if (refresh) begin
        sh_a_q <= cmp_a;
        sh_b_q <= cmp_b;
      end
    end
  end

  assign out_a = pin_a_q;
  assign out_b = pin_b_q;
  assign oe_a  = link_a & dir_a;
  assign oe_b  = link_b & dir_b;

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(cnt_q) && $stable(out_a) && $stable(out_b)));
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && wave_mode == M_FAST && cnt_q == top_val) |=> (cnt_q == '0));
  a_r5_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && phase && cnt_q == top_val && cnt_q != '0) |=> !up_q);
  a_r11_top_b: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && pwm && com_b[1] && cb == top_val && cnt_q == top_val)
      |=> (out_b == !$past(com_b[0])));
  a_r6_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !pwm && com_b == 2'b10 && cnt_q == cmp_b) |=> !out_b);
  a_r2_off_a: assert property (@(posedge clk) disable iff (!rst_n)
    (com_a == 2'b00) |-> !oe_a);
  a_r12_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !(cnt_en && (cnt_q == top_val || (phase && cnt_q == '0))))
      |=> $stable(sh_b_q));
endmodule

// File: tb/tb_pwm_cmp_gen.sv
module tb_pwm_cmp_gen;
  localparam int CLK_NS = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, mode_x = 1'b0, dir_a = 1'b0, dir_b = 1'b0;
  logic [1:0] wave_mode = '0, com_a = '0, com_b = '0;
  logic [W-1:0] top_val = '0, cmp_a = '0, cmp_b = '0;
  logic out_a, out_b, oe_a, oe_b;
  int n_run = 0, n_fail = 0;

  logic [W-1:0] m_cnt, m_sa, m_sb;
  logic m_up, m_pa, m_pb;

  always #(CLK_NS/2) clk = ~clk;

  pwm_cmp_gen #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wave_mode(wave_mode),
    .mode_x(mode_x), .top_val(top_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .com_a(com_a), .com_b(com_b), .dir_a(dir_a), .dir_b(dir_b),
    .out_a(out_a), .out_b(out_b), .oe_a(oe_a), .oe_b(oe_b));

  function automatic logic conn(input logic [1:0] code, input logic is_a);
    if (code == 2'b00) return 1'b0;
    if (wave_mode[1] && code == 2'b01) return is_a && mode_x;
    return 1'b1;
  endfunction

  function automatic logic [W-1:0] top_now();
    if (wave_mode == 2'b00) return '1;
    if (wave_mode == 2'b01) return cmp_a;
    return top_val;
  endfunction

  function automatic logic pin_rule(input logic [1:0] code, input logic is_a,
                                    input logic [W-1:0] cv, input logic cur);
    logic [W-1:0] t = top_now();
    logic hit = (m_cnt == cv);
    logic rise = (m_cnt == 0) || (m_up && m_cnt != t);
    if (!conn(code, is_a)) return cur;
    if (code == 2'b01) return hit ? !cur : cur;
    if (!wave_mode[1]) return hit ? code[0] : cur;
    if (wave_mode == 2'b10) begin
      if (m_cnt == t) return !code[0];
      return hit ? code[0] : cur;
    end
    if (cv == t) return (m_cnt == t) ? !code[0] : cur;
    if (!hit) return cur;
    return rise ? code[0] : !code[0];
  endfunction

  task automatic model_step();
    logic [W-1:0] t = top_now();
    logic [W-1:0] va = wave_mode[1] ? m_sa : cmp_a;
    logic [W-1:0] vb = wave_mode[1] ? m_sb : cmp_b;
    logic load = !wave_mode[1] || (cnt_en && (m_cnt == t || (wave_mode == 2'b11 && m_cnt == 0)));
    if (cnt_en) begin
      m_pa = pin_rule(com_a, 1'b1, va, m_pa);
      m_pb = pin_rule(com_b, 1'b0, vb, m_pb);
      if (wave_mode != 2'b11) begin
        m_up = 1'b1;
        m_cnt = (m_cnt == t) ? '0 : m_cnt + 1'b1;
      end else if ((m_cnt == 0 || m_up) && m_cnt != t) begin
        m_up = 1'b1;
        m_cnt = m_cnt + 1'b1;
      end else begin
        m_up = 1'b0;
        if (m_cnt != 0) m_cnt = m_cnt - 1'b1;
      end
    end
    if (load) begin
      m_sa = cmp_a;
      m_sb = cmp_b;
    end
  endtask

  task automatic check(input string tag);
    logic ea = conn(com_a, 1'b1) && dir_a;
    logic eb = conn(com_b, 1'b0) && dir_b;
    n_run++;
    if ({out_a, out_b, oe_a, oe_b} !== {m_pa, m_pb, ea, eb}) begin
      n_fail++;
      $display("FAIL %s: pins/oe got %b%b/%b%b expected %b%b/%b%b at t=%0t",
               tag, out_a, out_b, oe_a, oe_b, m_pa, m_pb, ea, eb, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_cnt = '0; m_up = 1'b1; m_pa = 1'b0; m_pb = 1'b0; m_sa = '0; m_sb = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1");
  endtask

  function automatic logic [W-1:0] pick(input logic [W-1:0] t);
    int r = int'($urandom % 8);
    if (r == 0) return '0;
    if (r == 1) return t;
    return W'($urandom % (int'(t) + 1));
  endfunction

  task automatic run(input string tag, input logic [1:0] md, input logic mx,
                     input logic [W-1:0] tv, input logic [W-1:0] ca, input logic [W-1:0] cb,
                     input logic [1:0] ka, input logic [1:0] kb, input logic da,
                     input logic db, input int ncyc, input logic churn);
    wave_mode = md; mode_x = mx; top_val = tv; cmp_a = ca; cmp_b = cb;
    com_a = ka; com_b = kb; dir_a = da; dir_b = db; cnt_en = 1'b1;
    do_reset();
    for (int i = 0; i < ncyc; i++) begin
      if (churn) begin
        cnt_en = ($urandom % 8) != 0;
        if ($urandom % 12 == 0 && md != 2'b01) cmp_a = pick(tv);
        if ($urandom % 12 == 0) cmp_b = pick(md == 2'b01 ? cmp_a : tv);
      end
      model_step();
      @(negedge clk);
      check(tag);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, got hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state, then R2 disconnected pins hold
    run("R2", 2'b10, 1'b0, 8'd9, 8'd3, 8'd5, 2'b00, 2'b00, 1'b1, 1'b1, 40, 1'b0);
    run("R3", 2'b10, 1'b0, 8'd9, 8'd3, 8'd5, 2'b10, 2'b11, 1'b0, 1'b0, 40, 1'b0);
    run("R4", 2'b00, 1'b0, 8'd0, 8'd7, 8'd200, 2'b01, 2'b01, 1'b1, 1'b1, 700, 1'b0);
    run("R4", 2'b01, 1'b0, 8'd0, 8'd20, 8'd5, 2'b01, 2'b11, 1'b1, 1'b1, 100, 1'b0);
    run("R5", 2'b11, 1'b0, 8'd10, 8'd4, 8'd7, 2'b10, 2'b11, 1'b1, 1'b1, 90, 1'b0);
    run("R6", 2'b01, 1'b0, 8'd0, 8'd15, 8'd6, 2'b10, 2'b11, 1'b1, 1'b1, 80, 1'b0);
    run("R7", 2'b10, 1'b0, 8'd12, 8'd5, 8'd0, 2'b10, 2'b11, 1'b1, 1'b1, 80, 1'b0);
    run("R8", 2'b10, 1'b0, 8'd12, 8'd5, 8'd5, 2'b10, 2'b01, 1'b1, 1'b1, 60, 1'b0);
    run("R9", 2'b11, 1'b0, 8'd8, 8'd0, 8'd8, 2'b10, 2'b11, 1'b1, 1'b1, 80, 1'b0);
    run("R10", 2'b11, 1'b1, 8'd8, 8'd3, 8'd3, 2'b01, 2'b01, 1'b1, 1'b1, 80, 1'b0);
    run("R10", 2'b10, 1'b0, 8'd8, 8'd3, 8'd3, 2'b01, 2'b10, 1'b1, 1'b1, 60, 1'b0);
    run("R11", 2'b10, 1'b0, 8'd9, 8'd9, 8'd9, 2'b10, 2'b11, 1'b1, 1'b1, 60, 1'b0);
    run("R11", 2'b11, 1'b0, 8'd9, 8'd9, 8'd9, 2'b11, 2'b10, 1'b1, 1'b1, 80, 1'b0);
    run("R12", 2'b10, 1'b1, 8'd15, 8'd6, 8'd2, 2'b11, 2'b10, 1'b1, 1'b1, 300, 1'b1);
    run("R13", 2'b11, 1'b1, 8'd11, 8'd5, 8'd11, 2'b01, 2'b10, 1'b1, 1'b0, 300, 1'b1);
    for (int k = 0; k < 60; k++) begin
      logic [1:0] md = 2'($urandom);
      logic [W-1:0] tv = W'(2 + $urandom % 30);
      logic [W-1:0] ca = (md == 2'b01) ? W'(1 + $urandom % 30) : pick(tv);
      logic [W-1:0] cb = pick(md == 2'b01 ? ca : tv);
      string tg = md[1] ? (md[0] ? "R9" : "R7") : "R6";
      run(tg, md, 1'($urandom), tv, ca, cb, 2'($urandom), 2'($urandom),
          1'($urandom), 1'($urandom), (md == 2'b00) ? 600 : 250, 1'b1);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule